// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

The block collects up to 96 level-sensitive interrupt lines, grouped in banks of 32, and reduces them to two processor requests: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line has its own 6-bit priority and a routing bit that sends it to one of the two requests. Each bank has a mask and a software-interrupt register. When a request fires, the controller records the winning line number. Software then reads that number, services the source, and re-arms the request through a control register.

The register window is 4 KB and takes 32-bit word accesses only. A write is applied on the clock edge while `req_i` and `we_i` are high. Read data is combinational from the current state, and reads have no side effects. A line that rises is marked pending. A fall on any line of a bank reloads that bank's pending bits from its live inputs and its software bits. An armed request fires when at least one pending, unmasked line of its class exists and the global disable is clear. Once fired, the request stays high until it is re-armed.

Top module: `intc_top`

## Requirements
- R1: Offset 0x000 reads the revision byte 0x21 and offset 0x014 always reads 1. Offset 0x04C reads 0, and writes to it change nothing.
- R2: After reset, both outputs are low and every mask bit is 1. All priorities, routing bits, pending bits, software bits and both resolved line numbers are 0.
- R3: Bank b sits at 0x080+0x20·b, and its +0x00 word reads the live inputs. A line rising from 0 to 1 sets its pending bit. If any line of a bank falls, that bank's pending becomes its current inputs OR its software bits.
- R4: Bank +0x04 reads and writes the whole mask, +0x08 clears the mask bits written as 1, and +0x0C sets them. A masked line never causes an output to assert.
- R5: Line n is configured at 0x100+4·n. Bits [7:2] hold its priority and bit 0 routes it to the fast request (1) or the normal request (0). Other bits read 0. Addresses past the last line read 0 and ignore writes.
- R6: Among the candidates, the lowest priority value wins, and a tie goes to the higher line number. The winner is captured when the output fires and reads back at 0x040 (normal) and 0x044 (fast). Reading either word changes nothing.
- R7: An armed output with at least one candidate goes high and disarms. It stays high until a write to 0x048 with bit 0 (normal) or bit 1 (fast) set, which drops it on that edge and re-arms it.
- R8: Bit 2 of 0x048 is a global disable, read back in bit 2. While it is set, neither output can newly assert. Once it is cleared, an armed class with candidates asserts.
- R9: Bank +0x10 ORs the written bits into the software bits and the pending bits, and it reads back the software bits. Bank +0x14 clears the written software bits and sets pending to the remaining software bits AND the inputs.
- R10: Bank +0x18 reads pending AND NOT mask for lines routed to the normal request. Bank +0x1C reads the same for lines routed to the fast request.
- R11: Offset 0x050 bits [1:0] are read/write idle-control bits. Bit 0 of 0x010 is a read/write auto-idle bit.
- R12: Writing 0x010 with bit 1 set returns all state to its reset value, including the auto-idle bit.
- R13: A bank index of 3 or more (0x0E0 to 0x0FF) reads 0, and writes to it change no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Word address (byte address bits 11:2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| lines_i | input | 96 | Interrupt source lines, active high |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest situation to reach is a priority tie across banks: two equal-priority lines in different banks must both be pending and unmasked while a lower-priority line is already being served. The stimulus sets up this tie on lines 40 and 70, with line 5 already firing at priority 10. It then re-arms the normal request, so the resolver sees all three lines in one evaluation. The falling-edge reload is also hard to reach, because it only shows when the bank still holds other high lines. The stimulus drops a line while a fast-routed neighbour stays high, then compares both pending readouts.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int PRIO_W = 6;
    localparam int BANK_W = 32;

    // register selector inside one bank slot (byte offset bits 4:2)
    typedef enum logic [2:0] {
        BR_RAW   = 3'd0,
        BR_MASK  = 3'd1,
        BR_MCLR  = 3'd2,
        BR_MSET  = 3'd3,
        BR_SWSET = 3'd4,
        BR_SWCLR = 3'd5,
        BR_PIRQ  = 3'd6,
        BR_PFIQ  = 3'd7
    } bank_reg_e;

    localparam logic [11:0] OFF_REV     = 12'h000;
    localparam logic [11:0] OFF_SYSCFG  = 12'h010;
    localparam logic [11:0] OFF_STAT    = 12'h014;
    localparam logic [11:0] OFF_SEL_IRQ = 12'h040;
    localparam logic [11:0] OFF_SEL_FIQ = 12'h044;
    localparam logic [11:0] OFF_CTRL    = 12'h048;
    localparam logic [11:0] OFF_PROT    = 12'h04C;
    localparam logic [11:0] OFF_IDLE    = 12'h050;
    localparam int          LINE_WORD0  = 64;   // 0x100 as word address

endpackage

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int W = BANK_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         soft_rst_i,
    input  logic [W-1:0] lines_i,
    input  logic         wr_i,
    input  bank_reg_e    reg_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] swi_o,
    output logic [W-1:0] pend_o
);

    typedef struct packed {
        logic [W-1:0] in;
        logic [W-1:0] mask;
        logic [W-1:0] swi;
        logic [W-1:0] pend;
    } bank_t;

    bank_t s_d, s_q;
    logic [W-1:0] rise, fall;

    always_comb begin
        s_d    = s_q;
        s_d.in = lines_i;
        rise   = lines_i & ~s_q.in;
        fall   = s_q.in & ~lines_i;
        if (|fall) begin
            s_d.pend = lines_i | s_q.swi;
        end else begin
            s_d.pend = s_q.pend | rise;
        end
        if (wr_i) begin
            case (reg_i)
                BR_MASK:  s_d.mask = wdata_i;
                BR_MCLR:  s_d.mask = s_q.mask & ~wdata_i;
                BR_MSET:  s_d.mask = s_q.mask | wdata_i;
                BR_SWSET: begin
                    s_d.swi  = s_q.swi | wdata_i;
                    s_d.pend = s_d.pend | s_d.swi;
                end
                BR_SWCLR: begin
                    s_d.swi  = s_q.swi & ~wdata_i;
                    s_d.pend = s_d.swi & lines_i;
                end
                default: ;
            endcase
        end
        if (soft_rst_i) begin
            s_d.mask = '1;
            s_d.swi  = '0;
            s_d.pend = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign raw_o  = s_q.in;
    assign mask_o = s_q.mask;
    assign swi_o  = s_q.swi;
    assign pend_o = s_q.pend;

endmodule

// File: rtl/intc_resolve.sv
module intc_resolve #(
    parameter int N  = 96,
    parameter int PW = 6,
    parameter int IW = 7
) (
    input  logic [N-1:0]         cand_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic                 any_o,
    output logic [IW-1:0]        idx_o
);

    logic [PW-1:0] best;

    // ascending scan with <= : lowest value wins, ties go to the higher line
    always_comb begin
        any_o = |cand_i;
        idx_o = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (prio_i[i] <= best)) begin
                best  = prio_i[i];
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int         NBANKS   = 3,
    parameter logic [7:0] REVISION = 8'h21
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [11:2]            addr_i,
    input  logic [31:0]            wdata_i,
    output logic [31:0]            rdata_o,
    input  logic [NBANKS*32-1:0]   lines_i,
    output logic                   irq_o,
    output logic                   fiq_o
);

    localparam int NLINES = NBANKS * BANK_W;
    localparam int SEL_W  = $clog2(NLINES);

    typedef struct packed {
        logic [NLINES-1:0][PRIO_W-1:0] prio;
        logic [NLINES-1:0]             route;
        logic [1:0]                    armed;
        logic [1:0]                    out;
        logic [1:0][SEL_W-1:0]         sel;
        logic                          dis;
        logic                          autoidle;
        logic [1:0]                    idle;
    } top_t;

    top_t s_d, s_q;

    // ---------------- address decode ----------------
    logic [11:0] addr_w;
    logic        wr, rd, soft_rst;
    logic        bank_hit, bank_ok, line_hit;
    logic [1:0]  bank_idx;
    bank_reg_e   breg;
    int          line_n;

    assign addr_w   = {addr_i, 2'b00};
    assign wr       = req_i & we_i;
    assign rd       = req_i & ~we_i;
    assign bank_hit = (addr_i[11:7] == 5'b00001);
    assign bank_idx = addr_i[6:5];
    assign bank_ok  = bank_hit && (int'(bank_idx) < NBANKS);
    assign breg     = bank_reg_e'(addr_i[4:2]);
    assign line_n   = int'(addr_i) - LINE_WORD0;
    assign line_hit = (line_n >= 0) && (line_n < NLINES);
    assign soft_rst = wr && (addr_w == OFF_SYSCFG) && wdata_i[1];

    // ---------------- banks ----------------
    logic [NBANKS-1:0][31:0] raw_b, mask_b, swi_b, pend_b, pirq_b, pfiq_b;
    logic [1:0][NLINES-1:0]  cand;
    logic [1:0]              any;
    logic [1:0][SEL_W-1:0]   idx;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr && bank_ok && (int'(bank_idx) == b);

        intc_bank #(.W(BANK_W)) u_bank (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .soft_rst_i (soft_rst),
            .lines_i    (lines_i[b*BANK_W +: BANK_W]),
            .wr_i       (bank_wr),
            .reg_i      (breg),
            .wdata_i    (wdata_i),
            .raw_o      (raw_b[b]),
            .mask_o     (mask_b[b]),
            .swi_o      (swi_b[b]),
            .pend_o     (pend_b[b])
        );

        assign pirq_b[b] = pend_b[b] & ~mask_b[b] & ~s_q.route[b*BANK_W +: BANK_W];
        assign pfiq_b[b] = pend_b[b] & ~mask_b[b] &  s_q.route[b*BANK_W +: BANK_W];
        assign cand[0][b*BANK_W +: BANK_W] = pirq_b[b];
        assign cand[1][b*BANK_W +: BANK_W] = pfiq_b[b];
    end

    // one resolver per request class (0 = normal, 1 = fast)
    for (genvar c = 0; c < 2; c++) begin : g_class
        intc_resolve #(.N(NLINES), .PW(PRIO_W), .IW(SEL_W)) u_res (
            .cand_i (cand[c]),
            .prio_i (s_q.prio),
            .any_o  (any[c]),
            .idx_o  (idx[c])
        );
    end

    // ---------------- next state ----------------
    always_comb begin
        s_d = s_q;
        for (int c = 0; c < 2; c++) begin
            if (s_q.armed[c] && any[c] && !s_q.dis) begin
                s_d.armed[c] = 1'b0;
                s_d.out[c]   = 1'b1;
                s_d.sel[c]   = idx[c];
            end
        end
        if (wr) begin
            case (addr_w)
                OFF_SYSCFG: s_d.autoidle = wdata_i[0];
                OFF_CTRL: begin
                    s_d.dis = wdata_i[2];
                    for (int c = 0; c < 2; c++) begin
                        if (wdata_i[c]) begin
                            s_d.out[c]   = 1'b0;
                            s_d.armed[c] = 1'b1;
                        end
                    end
                end
                OFF_IDLE: s_d.idle = wdata_i[1:0];
                default: begin
                    if (line_hit) begin
                        s_d.prio[line_n]  = wdata_i[7:2];
                        s_d.route[line_n] = wdata_i[0];
                    end
                end
            endcase
        end
        if (soft_rst) begin
            s_d       = '0;
            s_d.armed = '1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.armed <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    // ---------------- read path ----------------
    always_comb begin
        rdata_o = '0;
        if (rd) begin
            case (addr_w)
                OFF_REV:     rdata_o = {24'b0, REVISION};
                OFF_SYSCFG:  rdata_o = {31'b0, s_q.autoidle};
                OFF_STAT:    rdata_o = 32'd1;
                OFF_SEL_IRQ: rdata_o = {{(32-SEL_W){1'b0}}, s_q.sel[0]};
                OFF_SEL_FIQ: rdata_o = {{(32-SEL_W){1'b0}}, s_q.sel[1]};
                OFF_CTRL:    rdata_o = {29'b0, s_q.dis, 2'b00};
                OFF_PROT:    rdata_o = '0;
                OFF_IDLE:    rdata_o = {30'b0, s_q.idle};
                default: begin
                    if (bank_ok) begin
                        case (breg)
                            BR_RAW:   rdata_o = raw_b[bank_idx];
                            BR_MASK:  rdata_o = mask_b[bank_idx];
                            BR_SWSET: rdata_o = swi_b[bank_idx];
                            BR_PIRQ:  rdata_o = pirq_b[bank_idx];
                            BR_PFIQ:  rdata_o = pfiq_b[bank_idx];
                            default:  rdata_o = '0;
                        endcase
                    end else if (line_hit) begin
                        rdata_o = {{(32-PRIO_W-2){1'b0}}, s_q.prio[line_n],
                                   1'b0, s_q.route[line_n]};
                    end
                end
            endcase
        end
    end

    assign irq_o = s_q.out[0];
    assign fiq_o = s_q.out[1];

endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
    parameter int         NBANKS   = 3,
    parameter logic [7:0] REVISION = 8'h21
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_i,
    input logic        we_i,
    input logic [11:2] addr_i,
    input logic [1:0]  ctl_bits_i,
    input logic [31:0] rdata_o,
    input logic        irq_o,
    input logic        fiq_o,
    input logic        dis_i
);

    logic wr_ctrl, wr_sys;
    assign wr_ctrl = req_i && we_i && ({addr_i, 2'b00} == 12'h048);
    assign wr_sys  = req_i && we_i && ({addr_i, 2'b00} == 12'h010);

    // R7: a fired normal request holds until re-armed or soft reset
    assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o && !(wr_ctrl && ctl_bits_i[0]) && !(wr_sys && ctl_bits_i[1]) |=> irq_o);

    // R7: same for the fast request
    assert_fiq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fiq_o && !(wr_ctrl && ctl_bits_i[1]) && !(wr_sys && ctl_bits_i[1]) |=> fiq_o);

    // R7: re-arm drops the output on that edge
    assert_rearm_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ctrl && ctl_bits_i[0] |=> !irq_o);

    // R12: soft reset clears both outputs
    assert_soft_reset_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_sys && ctl_bits_i[1] |=> !irq_o && !fiq_o);

    // R8: no new assertion while disabled
    assert_disable_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dis_i && !irq_o |=> !irq_o);

    // R1: revision word
    assert_revision_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i && !we_i && ({addr_i, 2'b00} == 12'h000) |-> rdata_o == {24'b0, REVISION});

    // R13: unpopulated bank slots read zero
    assert_bank_range_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i && !we_i && (addr_i[11:7] == 5'b00001) && (int'(addr_i[6:5]) >= NBANKS)
        |-> rdata_o == 32'd0);

endmodule

bind intc_top intc_chk #(.NBANKS(NBANKS), .REVISION(REVISION)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .ctl_bits_i (wdata_i[1:0]),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .dis_i      (s_q.dis)
);

// File: tb/test_intc_top.sv
module test_intc_top;

    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [11:0] baddr = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [95:0] lines = '0;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    intc_top i_intc_top (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (req_i),
        .we_i    (we_i),
        .addr_i  (baddr[11:2]),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .lines_i (lines),
        .irq_o   (irq_o),
        .fiq_o   (fiq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0, 32'h21,       4'd1},  // R1 revision
        '{1'b0, 12'h014, 32'h0, 32'h1,        4'd1},  // R1 reset done
        '{1'b1, 12'h04C, 32'h1, 32'h0,        4'd1},
        '{1'b0, 12'h04C, 32'h0, 32'h0,        4'd1},  // R1 write ignored
        '{1'b0, 12'h084, 32'h0, 32'hFFFFFFFF, 4'd2},  // R2 mask reset
        '{1'b0, 12'h0C4, 32'h0, 32'hFFFFFFFF, 4'd2},
        '{1'b0, 12'h1FC, 32'h0, 32'h0,        4'd2},  // R2 line cfg reset
        '{1'b1, 12'h050, 32'h7, 32'h0,        4'd11},
        '{1'b0, 12'h050, 32'h0, 32'h3,        4'd11}, // R11 idle bits
        '{1'b1, 12'h050, 32'h0, 32'h0,        4'd11},
        '{1'b1, 12'h210, 32'hFF, 32'h0,       4'd5},
        '{1'b0, 12'h210, 32'h0, 32'hFD,       4'd5},  // R5 field mask
        '{1'b1, 12'h210, 32'h0, 32'h0,        4'd5},
        '{1'b1, 12'h280, 32'hFF, 32'h0,       4'd5},
        '{1'b0, 12'h280, 32'h0, 32'h0,        4'd5},  // R5 past last line
        '{1'b0, 12'h0E4, 32'h0, 32'h0,        4'd13}  // R13 empty slot
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk_i);
        req_i = 1'b1; we_i = 1'b1; baddr = a; wdata_i = d;
        @(negedge clk_i);
        req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk_i);
        req_i = 1'b1; we_i = 1'b0; baddr = a;
        #1;
        check(rdata_o, exp, tag);
        req_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_ni = 1'b1;
        idle(1);

        // R2 reset state
        check({31'b0, irq_o}, 32'd0, "R2 irq after reset");
        check({31'b0, fiq_o}, 32'd0, "R2 fiq after reset");
        rd(12'h040, 32'd0, "R2 resolved line");
        rd(12'h098, 32'd0, "R2 pending");

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].wr) wr(VECS[v].a, VECS[v].d);
            else rd(VECS[v].a, VECS[v].e, $sformatf("R%0d vector %0d", VECS[v].r, v));
        end

        // masked line never fires (R4), raw input visible (R3)
        @(negedge clk_i); lines[5] = 1'b1;
        idle(3);
        check({31'b0, irq_o}, 32'd0, "R4 masked line");
        rd(12'h080, 32'h20, "R3 raw inputs");
        rd(12'h098, 32'h0, "R10 masked pending hidden");

        // unmask via clear alias
        wr(12'h088, 32'h20);
        idle(3);
        check({31'b0, irq_o}, 32'd1, "R7 irq asserts");
        rd(12'h040, 32'd5, "R6 winner");
        rd(12'h040, 32'd5, "R6 read no side effect");
        rd(12'h098, 32'h20, "R10 irq pending");
        rd(12'h084, 32'hFFFFFFDF, "R4 mask clear alias");

        // priority tie across banks
        wr(12'h114, 32'h28);
        wr(12'h1A0, 32'h08);
        wr(12'h218, 32'h08);
        @(negedge clk_i); lines[40] = 1'b1; lines[70] = 1'b1;
        wr(12'h0A8, 32'h100);
        wr(12'h0C8, 32'h40);
        wr(12'h048, 32'h1);
        check({31'b0, irq_o}, 32'd0, "R7 rearm drops output");
        idle(3);
        check({31'b0, irq_o}, 32'd1, "R7 refire");
        rd(12'h040, 32'd70, "R6 tie to higher line");
        rd(12'h114, 32'h28, "R5 line config");

        // fast request
        wr(12'h10C, 32'h01);
        @(negedge clk_i); lines[3] = 1'b1;
        wr(12'h084, 32'hFFFFFFD7);
        idle(3);
        check({31'b0, fiq_o}, 32'd1, "R7 fiq asserts");
        rd(12'h044, 32'd3, "R6 fiq winner");
        rd(12'h09C, 32'h8, "R10 fiq pending");
        rd(12'h098, 32'h20, "R10 irq pending split");

        // set alias masks everything normal
        wr(12'h08C, 32'h20);
        wr(12'h0AC, 32'h100);
        wr(12'h0CC, 32'h40);
        wr(12'h048, 32'h1);
        idle(3);
        check({31'b0, irq_o}, 32'd0, "R4 set alias masks");
        rd(12'h084, 32'hFFFFFFF7, "R4 mask set alias");

        // global disable
        wr(12'h048, 32'h4);
        wr(12'h088, 32'h20);
        idle(3);
        check({31'b0, irq_o}, 32'd0, "R8 disabled");
        rd(12'h048, 32'h4, "R8 disable readback");
        wr(12'h048, 32'h0);
        idle(3);
        check({31'b0, irq_o}, 32'd1, "R8 enable fires");
        rd(12'h040, 32'd5, "R8 winner after enable");

        // software interrupt
        wr(12'h0A8, 32'h2);
        wr(12'h0B0, 32'h2);
        wr(12'h048, 32'h1);
        idle(3);
        check({31'b0, irq_o}, 32'd1, "R9 swi fires");
        rd(12'h040, 32'd33, "R9 swi winner");
        rd(12'h0B0, 32'h2, "R9 swi readback");
        rd(12'h0B8, 32'h2, "R10 bank1 pending");
        wr(12'h0B4, 32'h2);
        rd(12'h0B8, 32'h0, "R9 swi clear reloads pending");
        rd(12'h0B0, 32'h0, "R9 swi cleared");

        // falling input reloads bank pending
        @(negedge clk_i); lines[5] = 1'b0;
        idle(2);
        rd(12'h098, 32'h0, "R3 fall reload irq");
        rd(12'h09C, 32'h8, "R3 fall reload keeps high line");
        @(negedge clk_i); lines[5] = 1'b1;
        idle(2);
        rd(12'h098, 32'h20, "R3 rise after fall");

        // empty bank slot writes ignored
        wr(12'h0E8, 32'hFFFFFFFF);
        wr(12'h0E4, 32'h0);
        rd(12'h084, 32'hFFFFFFD7, "R13 bank0 mask untouched");
        rd(12'h0C4, 32'hFFFFFFFF, "R13 bank2 mask untouched");
        rd(12'h0E4, 32'h0, "R13 read zero");

        // auto-idle and soft reset
        wr(12'h010, 32'h1);
        rd(12'h010, 32'h1, "R11 autoidle");
        wr(12'h010, 32'h2);
        check({31'b0, irq_o}, 32'd0, "R12 irq cleared");
        check({31'b0, fiq_o}, 32'd0, "R12 fiq cleared");
        rd(12'h084, 32'hFFFFFFFF, "R12 mask reset");
        rd(12'h010, 32'h0, "R12 autoidle reset");
        rd(12'h044, 32'h0, "R12 winner reset");
        rd(12'h10C, 32'h0, "R12 line config reset");
        idle(3);
        check({31'b0, irq_o | fiq_o}, 32'd0, "R12 quiet after reset");

        finish_run();
    end

endmodule